// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is an eight-stage shift register that takes data either serially, one bit per active edge, or broadside from an eight-bit parallel input. Only the final stage leaves the block, so a typical use is parallel-to-serial conversion: load a byte, then shift it out bit by bit while new serial data enters at the first stage.

The register does not step on the system clock directly. Two slow control inputs, a shift clock and an inhibit, are sampled in the fast system-clock domain and combined as NOR(shift_clk, shift_inh). The register advances once for every low-to-high transition of that combined level. A free-running shift clock can therefore be paused by raising the inhibit. Raising the inhibit while the shift clock is low is a misuse, because lowering it again produces an extra edge. A sticky flag records each such misuse. An active-low asynchronous clear empties the register and the flag, and it overrides everything else.

Top module: `gated_piso_shifter`

## Requirements
- R1: On an active edge with shift_mode = 1 (shift), stage 0 takes ser_in, each stage k takes the old value of stage k-1, and q_last takes the old value of stage 6.
- R2: On an active edge with shift_mode = 0 (load), stage k takes par_in[k] (par_in[0] is the first stage, par_in[7] the last), so q_last becomes par_in[7]. ser_in has no effect during a load.
- R3: An active edge is a sys_clk cycle in which NOR(shift_clk, shift_inh) is high while it was low in the previous cycle. The new stage values appear on q_last right after that sys_clk rising edge.
- R4: Keeping shift_inh high blocks all updates however shift_clk toggles. Keeping shift_clk high blocks all updates however shift_inh toggles.
- R5: In a cycle with no active edge, all stages keep their values.
- R6: clr_n low asynchronously forces every stage and inh_violation to 0, and it blocks any active edge while it is low.
- R7: inh_violation goes to 1 after a sys_clk cycle in which shift_inh is high, was low in the previous cycle, and shift_clk is low. It stays at 1 until clr_n or sys_rst clears it.
- R8: Raising shift_inh while shift_clk is high does not set inh_violation.
- R9: sys_rst (synchronous, active high) clears the stages and the flag. It leaves the edge detector treating the combined level and the inhibit as previously high, so the first cycle after reset is never an active edge and never a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Fast system clock; all sampling happens on its rising edge |
| sys_rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Asynchronous active-low clear of stages and flag |
| shift_clk | input | 1 | Shift clock level, sampled in sys_clk |
| shift_inh | input | 1 | Active-high clock inhibit, sampled in sys_clk |
| shift_mode | input | 1 | 1 = shift serially, 0 = load parallel |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | STAGES | Broadside data, bit k to stage k |
| q_last | output | 1 | Value of the last stage |
| inh_violation | output | 1 | Sticky flag for an inhibit raised while shift_clk is low |

## Verification
The assertions assume that shift_clk, shift_inh, shift_mode, ser_in and par_in are synchronous to sys_clk and stable around its rising edge. They also assume that clr_n is released in step with sys_clk. The stimulus changes every input only on the falling edge of sys_clk and holds it for at least one full cycle. Clear pulses therefore always span a sampling edge, and none of the sampled levels ever sits on an edge.

// File: rtl/pisr_pkg.sv
package pisr_pkg;

    localparam int unsigned STAGE_COUNT = 8;

    typedef enum logic {
        LOAD_MODE  = 1'b0,
        SHIFT_MODE = 1'b1
    } chain_mode_e;

    typedef struct packed {
        logic gate;
        logic inh;
    } samp_t;

    localparam samp_t SAMP_IDLE = '{gate: 1'b1, inh: 1'b1};

    function automatic logic gated_level(input logic clk_lvl, input logic inh_lvl);
        return ~(clk_lvl | inh_lvl);
    endfunction

    function automatic logic misuse_raise(input logic inh_now, input logic inh_prev,
                                          input logic clk_lvl);
        return inh_now & ~inh_prev & ~clk_lvl;
    endfunction

endpackage

// File: rtl/pisr_edge_unit.sv
module pisr_edge_unit
    import pisr_pkg::*;
(
    input  logic sys_clk,
    input  logic sys_rst,
    input  logic clr_n,
    input  logic shift_clk,
    input  logic shift_inh,
    output logic act_edge,
    output logic inh_violation
);

    samp_t prev_q;
    logic  gate_now;
    logic  bad_raise;

    assign gate_now  = gated_level(shift_clk, shift_inh);
    assign act_edge  = gate_now & ~prev_q.gate;
    assign bad_raise = misuse_raise(shift_inh, prev_q.inh, shift_clk);

    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            prev_q <= SAMP_IDLE;
        end else begin
            prev_q <= '{gate: gate_now, inh: shift_inh};
        end
    end

    always_ff @(posedge sys_clk or negedge clr_n) begin
        if (!clr_n) begin
            inh_violation <= 1'b0;
        end else if (sys_rst) begin
            inh_violation <= 1'b0;
        end else if (bad_raise) begin
            inh_violation <= 1'b1;
        end
    end

endmodule

// File: rtl/pisr_stage_chain.sv
module pisr_stage_chain
    import pisr_pkg::*;
#(
    parameter int unsigned N = STAGE_COUNT
) (
    input  logic          sys_clk,
    input  logic          sys_rst,
    input  logic          clr_n,
    input  logic          step,
    input  chain_mode_e   mode,
    input  logic          ser_in,
    input  logic [N-1:0]  par_in,
    output logic [N-1:0]  stage_q
);

    logic [N-1:0] shifted;
    logic [N-1:0] next_q;

    generate
        if (N == 1) begin : g_single
            assign shifted = ser_in;
        end else begin : g_multi
            assign shifted = {stage_q[N-2:0], ser_in};
        end
    endgenerate

    always_comb begin
        unique case (mode)
            SHIFT_MODE: next_q = shifted;
            default:    next_q = par_in;
        endcase
    end

    always_ff @(posedge sys_clk or negedge clr_n) begin
        if (!clr_n) begin
            stage_q <= '0;
        end else if (sys_rst) begin
            stage_q <= '0;
        end else if (step) begin
            stage_q <= next_q;
        end
    end

endmodule

// File: rtl/gated_piso_shifter.sv
module gated_piso_shifter
    import pisr_pkg::*;
#(
    parameter int unsigned STAGES = STAGE_COUNT
) (
    input  logic              sys_clk,
    input  logic              sys_rst,
    input  logic              clr_n,
    input  logic              shift_clk,
    input  logic              shift_inh,
    input  logic              shift_mode,
    input  logic              ser_in,
    input  logic [STAGES-1:0] par_in,
    output logic              q_last,
    output logic              inh_violation
);

    localparam int unsigned LAST = STAGES - 1;

    logic              act_edge;
    logic [STAGES-1:0] stage_q;
    chain_mode_e       mode_sel;

    assign mode_sel = chain_mode_e'(shift_mode);

    pisr_edge_unit u_edge (
        .sys_clk       (sys_clk),
        .sys_rst       (sys_rst),
        .clr_n         (clr_n),
        .shift_clk     (shift_clk),
        .shift_inh     (shift_inh),
        .act_edge      (act_edge),
        .inh_violation (inh_violation)
    );

    pisr_stage_chain #(.N(STAGES)) u_chain (
        .sys_clk (sys_clk),
        .sys_rst (sys_rst),
        .clr_n   (clr_n),
        .step    (act_edge),
        .mode    (mode_sel),
        .ser_in  (ser_in),
        .par_in  (par_in),
        .stage_q (stage_q)
    );

    assign q_last = stage_q[LAST];

endmodule

// File: rtl/pisr_checker.sv
module pisr_checker #(
    parameter int unsigned N = 8
) (
    input logic         sys_clk,
    input logic         sys_rst,
    input logic         clr_n,
    input logic         shift_clk,
    input logic         shift_mode,
    input logic         ser_in,
    input logic [N-1:0] par_in,
    input logic         act_edge,
    input logic [N-1:0] stage_q,
    input logic         q_last,
    input logic         inh_violation
);

    a_r1_shift_moves: assert property (@(posedge sys_clk) disable iff (sys_rst || !clr_n)
        act_edge && shift_mode |=> stage_q[0] == $past(ser_in) && q_last == $past(stage_q[N-2]));

    a_r2_load_captures: assert property (@(posedge sys_clk) disable iff (sys_rst || !clr_n)
        act_edge && !shift_mode |=> stage_q == $past(par_in));

    a_r5_hold_no_edge: assert property (@(posedge sys_clk) disable iff (sys_rst || !clr_n)
        !act_edge |=> $stable(stage_q));

    a_r6_clear_empties: assert property (@(posedge sys_clk) disable iff (sys_rst)
        !clr_n |-> stage_q == '0 && !inh_violation);

    a_r7_flag_sticky: assert property (@(posedge sys_clk) disable iff (sys_rst || !clr_n)
        inh_violation |=> inh_violation);

    a_r8_clk_high_safe: assert property (@(posedge sys_clk) disable iff (sys_rst || !clr_n)
        shift_clk && !inh_violation |=> !inh_violation);

endmodule

bind gated_piso_shifter pisr_checker #(.N(STAGES)) u_chk (
    .sys_clk       (sys_clk),
    .sys_rst       (sys_rst),
    .clr_n         (clr_n),
    .shift_clk     (shift_clk),
    .shift_mode    (shift_mode),
    .ser_in        (ser_in),
    .par_in        (par_in),
    .act_edge      (act_edge),
    .stage_q       (stage_q),
    .q_last        (q_last),
    .inh_violation (inh_violation)
);

// File: tb/gated_piso_shifter_bench.sv
module gated_piso_shifter_bench;

    logic       sys_clk = 1'b0;
    logic       sys_rst = 1'b1;
    logic       clr_n = 1'b1;
    logic       shift_clk = 1'b0;
    logic       shift_inh = 1'b0;
    logic       shift_mode = 1'b0;
    logic       ser_in = 1'b0;
    logic [7:0] par_in = 8'h00;
    logic       q_last;
    logic       inh_violation;

    int unsigned n_run = 0;
    int unsigned n_fail = 0;
    bit          done = 1'b0;

    logic [7:0] m_stage = 8'h00;
    logic       m_flag = 1'b0;
    logic       m_pg = 1'b1;
    logic       m_pi = 1'b1;

    always #4 sys_clk = ~sys_clk;

    gated_piso_shifter u_gated_piso_shifter (
        .sys_clk       (sys_clk),
        .sys_rst       (sys_rst),
        .clr_n         (clr_n),
        .shift_clk     (shift_clk),
        .shift_inh     (shift_inh),
        .shift_mode    (shift_mode),
        .ser_in        (ser_in),
        .par_in        (par_in),
        .q_last        (q_last),
        .inh_violation (inh_violation)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(q_last === m_stage[7], tag, {7'd0, q_last}, {7'd0, m_stage[7]});
        chk(inh_violation === m_flag, {tag, " flag"}, {7'd0, inh_violation}, {7'd0, m_flag});
    endtask

    // Called at a falling edge: drive, predict the next rising edge, wait to the next falling edge.
    task automatic step(input logic c, input logic i, input logic md, input logic s,
                        input logic [7:0] p, input logic cl, input logic r);
        logic gate;
        logic act;
        logic bad;
        shift_clk = c; shift_inh = i; shift_mode = md; ser_in = s; par_in = p;
        clr_n = cl; sys_rst = r;
        gate = ~(c | i);
        if (r) begin
            m_stage = 8'h00; m_flag = 1'b0; m_pg = 1'b1; m_pi = 1'b1;
        end else begin
            act = gate & ~m_pg;
            bad = i & ~m_pi & ~c;
            if (!cl) begin
                m_stage = 8'h00; m_flag = 1'b0;
            end else begin
                if (act) m_stage = md ? {m_stage[6:0], s} : p;
                if (bad) m_flag = 1'b1;
            end
            m_pg = gate; m_pi = i;
        end
        @(negedge sys_clk);
    endtask

    task automatic pulse(input logic md, input logic s, input logic [7:0] p, input string tag);
        step(1'b1, 1'b0, md, s, p, 1'b1, 1'b0);
        compare(tag);
        step(1'b0, 1'b0, md, s, p, 1'b1, 1'b0);
        compare(tag);
    endtask

    task automatic t_reset;
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b1);
        compare("R9 reset state");
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b0);
            compare("R9 no edge after reset");
        end
    endtask

    task automatic t_load;
        pulse(1'b0, 1'b0, 8'hA5, "R2 load A5");
        pulse(1'b0, 1'b1, 8'h3C, "R2 load 3C ser ignored");
        for (int k = 0; k < 8; k++) pulse(1'b1, 1'b0, 8'h00, "R3 unload");
    endtask

    task automatic t_shift;
        logic [7:0] pat = 8'b1011_0010;
        pulse(1'b0, 1'b0, 8'h00, "R2 clear by load");
        for (int k = 7; k >= 0; k--) pulse(1'b1, pat[k], 8'hFF, "R1 shift in");
        for (int k = 0; k < 8; k++) pulse(1'b1, 1'b0, 8'hFF, "R1 shift out");
    endtask

    task automatic t_hold;
        pulse(1'b0, 1'b0, 8'h80, "R2 load 80");
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
            compare("R5 hold with clk high");
        end
    endtask

    task automatic t_inhibit;
        step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        compare("R8 inhibit raised with clk high");
        for (int k = 0; k < 6; k++) begin
            step(k[0], 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
            compare("R4 inhibit blocks clk");
        end
        for (int k = 0; k < 6; k++) begin
            step(1'b1, k[0], 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
            compare("R4 clk high blocks inh");
        end
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        compare("R3 edge after resume");
    endtask

    task automatic t_violation;
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b0);
        compare("R7 flag set");
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b0);
        compare("R7 spurious edge");
        pulse(1'b1, 1'b1, 8'h00, "R7 flag sticky");
        step(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
        compare("R6 clear");
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0);
        compare("R6 edge blocked by clear");
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b0);
        compare("R6 release");
    endtask

    task automatic t_random;
        for (int k = 0; k < 600; k++) begin
            logic [7:0] pv = 8'($urandom);
            logic cl = ($urandom % 25) != 0;
            step(1'($urandom), ($urandom % 4) == 0, 1'($urandom), 1'($urandom), pv, cl, 1'b0);
            compare("R3 random");
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R3 watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge sys_clk);
        t_reset();
        t_load();
        t_shift();
        t_hold();
        t_inhibit();
        t_violation();
        t_random();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule